// File: doc/BRIEF.md
# SPI Configuration Register Slave

This block lets a host read and write a bank of eight-bit configuration registers over a four-wire serial link. Each register access takes two bytes under one low period of the configuration select. The first byte is a command. It holds a zero framing bit at each end, with a read/write flag and the register address between them. During a write, the second byte carries the value to store. During a read, the slave shifts the addressed register out on its serial output while the host clocks the second byte. Several such two-byte accesses may follow one another while the select stays low.

The serial clock, data input and both selects come in from the host asynchronously. Each passes through a flop synchroniser, and all decoding runs in the system clock domain. A second active-low select belongs to a separate data path that is not part of this block. When the configuration select is low, configuration access wins and the data-path indication stays off. The register bank is visible as one flat vector, and every write is also reported as a one-cycle strobe with its address and data.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, every register reads zero, `sdo` and `sdo_oe` are 0, and no write strobe has been issued.
- R2: A command byte with bit 7 = 0 (start), bit 6 = 0 (write), bits 5..1 = address and bit 0 = 0 (stop), followed by a data byte sent MSB first, stores that byte in the addressed register. Bit values are taken on rising `sck`.
- R3: A command byte with bit 6 = 1 (read) returns the addressed register MSB first on `sdo` during the second byte. The host samples it on rising `sck`, and no register changes.
- R4: A command byte whose bit 7 or bit 0 is 1 raises `cmd_bad` for one cycle. Its second byte changes no register, and a read framed this way returns 0.
- R5: If the select rises before a byte is complete, the partial byte is dropped and nothing is committed. The next select-low period starts again with a command byte.
- R6: While `cfg_sel_n` is low, the configuration interface is used whatever `dat_sel_n` is, and `dat_path_sel` is 0. With only `dat_sel_n` low, `dat_path_sel` is 1, `sdo_oe` is 0, and serial traffic changes no register.
- R7: While the configuration select is high, `sdo` and `sdo_oe` are 0.
- R8: Two-byte accesses may follow back to back within one select-low period, each one decoded as a fresh command.
- R9: Each committed write produces exactly one single-cycle `wr_stb` pulse, with `wr_addr` and `wr_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from host, idles low |
| sdi | input | 1 | Serial data from host |
| cfg_sel_n | input | 1 | Active-low configuration select (priority) |
| dat_sel_n | input | 1 | Active-low data-path select |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | High while the configuration interface owns `sdo` |
| dat_path_sel | output | 1 | Data path selected and configuration idle |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | ADDR_W | Address of the committed write |
| wr_data | output | ADDR_W+3 | Data of the committed write |
| cmd_bad | output | 1 | One-cycle pulse on a badly framed command byte |
| reg_flat | output | (2**ADDR_W)*(ADDR_W+3) | All registers, register n at bits n*8 and up |

## Verification
The bench builds the block with its default ADDR_W of 5, which gives 32 eight-bit registers. At this size every address can be written with a distinct value computed arithmetically and then read back over the serial line. Around that full sweep, the bench drives both framing errors, aborts in the command byte and in the data byte, every combination of the two selects, and chained accesses within one select. The serial clock runs at one sixteenth of the system clock, which leaves room for the synchroniser latency in every bit.

// File: rtl/spi_cfg_pkg.sv
// Shared definitions for the SPI configuration port.
// Assumes eight-bit bytes built from a start bit, a flag, an address and a stop bit.
package spi_cfg_pkg;

    // Which byte of a two-byte access is in progress.
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    // Bit positions inside the command byte, counted from the LSB.
    localparam int STOP_POS  = 0;
    localparam int ADDR_LSB  = 1;

endpackage

// File: rtl/spi_cfg_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 2 and that each bit is independent (no bus coherency).
module spi_cfg_sync #(
    parameter int             WIDTH   = 4,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d_async;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/spi_cfg_framer.sv
// Serial byte engine: samples on rising SCK, shifts out on falling SCK,
// and decodes the command/data byte pair into a write or a read load.
// Assumes synchronised inputs and an SCK at most a quarter of the clock rate.
module spi_cfg_framer
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int DATA_W = ADDR_W + 3,
    localparam int CW     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic              cfg_act,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo_bit,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_bad
);

    localparam int START_POS = DATA_W - 1;
    localparam int RW_POS    = DATA_W - 2;
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

    logic              sck_d;
    logic [CW-1:0]     bit_cnt;
    phase_e            phase;
    logic [DATA_W-2:0] rx;
    logic [DATA_W-1:0] tx;
    logic              cmd_ok;
    logic              cmd_rd;
    logic [ADDR_W-1:0] cmd_addr;

    logic              rise;
    logic              fall;
    logic              last;
    logic [DATA_W-1:0] byte_now;
    logic              frame_ok;

    // Edge detection and decode of the byte as it completes.
    always_comb begin
        rise     = sck_s && !sck_d;
        fall     = !sck_s && sck_d;
        last     = rise && (bit_cnt == LAST_BIT);
        byte_now = {rx, sdi_s};
        frame_ok = !byte_now[START_POS] && !byte_now[STOP_POS];
        rd_addr  = byte_now[ADDR_LSB +: ADDR_W];
    end

    // Bit/byte sequencing, command capture, write commit and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            bit_cnt  <= '0;
            phase    <= PH_CMD;
            rx       <= '0;
            tx       <= '0;
            cmd_ok   <= 1'b0;
            cmd_rd   <= 1'b0;
            cmd_addr <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cmd_bad  <= 1'b0;
        end else begin
            sck_d   <= sck_s;
            wr_stb  <= 1'b0;
            cmd_bad <= 1'b0;
            if (!cfg_act) begin
                bit_cnt <= '0;
                phase   <= PH_CMD;
                rx      <= '0;
                tx      <= '0;
                cmd_ok  <= 1'b0;
            end else if (rise) begin
                rx      <= byte_now[DATA_W-2:0];
                bit_cnt <= last ? '0 : bit_cnt + 1'b1;
                if (last && phase == PH_CMD) begin
                    cmd_ok   <= frame_ok;
                    cmd_rd   <= byte_now[RW_POS];
                    cmd_addr <= rd_addr;
                    cmd_bad  <= !frame_ok;
                    tx       <= (frame_ok && byte_now[RW_POS]) ? rd_word : '0;
                    phase    <= PH_DATA;
                end else if (last) begin
                    if (cmd_ok && !cmd_rd) begin
                        wr_stb  <= 1'b1;
                        wr_addr <= cmd_addr;
                        wr_data <= byte_now;
                    end
                    cmd_ok <= 1'b0;
                    phase  <= PH_CMD;
                end
            end else if (fall && bit_cnt != '0) begin
                tx <= {tx[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign sdo_bit = tx[DATA_W-1];

endmodule

// File: rtl/spi_cfg_regbank.sv
// Register bank: one write port driven by the commit strobe, one
// combinational read port for the serial read path, and a flat view.
// Assumes a single writer and a zero reset value for every register.
module spi_cfg_regbank #(
    parameter int ADDR_W = 5,
    localparam int DATA_W   = ADDR_W + 3,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_word,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    // Store committed writes; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_stb) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_word = mem[rd_addr];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign reg_flat[g*DATA_W +: DATA_W] = mem[g];
    end

endmodule

// File: rtl/spi_cfg_port.sv
// Top of the SPI configuration register slave. Synchronises the serial
// pins, resolves select priority, and joins the byte engine to the bank.
// Assumes SCK idles low and runs well below the system clock rate.
module spi_cfg_port #(
    parameter int ADDR_W = 5,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W   = ADDR_W + 3,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck,
    input  logic                       sdi,
    input  logic                       cfg_sel_n,
    input  logic                       dat_sel_n,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic                       dat_path_sel,
    output logic                       wr_stb,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [DATA_W-1:0]          wr_data,
    output logic                       cmd_bad,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat
);

    logic [3:0]        pins_s;
    logic              cfg_act;
    logic              sdo_bit;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;

    spi_cfg_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({dat_sel_n, cfg_sel_n, sdi, sck}),
        .q_sync  (pins_s)
    );

    // Configuration select wins over the data-path select.
    always_comb begin
        cfg_act      = !pins_s[2];
        dat_path_sel = pins_s[2] && !pins_s[3];
        sdo_oe       = cfg_act;
        sdo          = cfg_act && sdo_bit;
    end

    spi_cfg_framer #(.ADDR_W(ADDR_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[0]),
        .sdi_s   (pins_s[1]),
        .cfg_act (cfg_act),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .sdo_bit (sdo_bit),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd_bad (cmd_bad)
    );

    spi_cfg_regbank #(.ADDR_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_word  (rd_word),
        .reg_flat (reg_flat)
    );

endmodule

// File: rtl/spi_cfg_port_chk.sv
// Property checker for spi_cfg_port, attached with bind below.
// Assumes it sees the top's ports and the internal select-active signal.
module spi_cfg_port_chk #(
    parameter int ADDR_W = 5,
    localparam int DATA_W   = ADDR_W + 3,
    localparam int NUM_REGS = 1 << ADDR_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_act,
    input logic                       sdo,
    input logic                       sdo_oe,
    input logic                       dat_path_sel,
    input logic                       wr_stb,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [NUM_REGS*DATA_W-1:0] reg_flat
);

    logic              prev_stb;
    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_data;

    // Remember the last strobe so the following cycle can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_stb  <= 1'b0;
            prev_addr <= '0;
            prev_data <= '0;
        end else begin
            prev_stb  <= wr_stb;
            prev_addr <= wr_addr;
            prev_data <= wr_data;
        end
    end

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prev_stb |-> reg_flat[prev_addr*DATA_W +: DATA_W] == prev_data);

    p_regs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(reg_flat));

    p_idle_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_act && $past(!cfg_act)) |-> !wr_stb);

    p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dat_path_sel |-> !sdo_oe);

    p_quiet_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

endmodule

bind spi_cfg_port spi_cfg_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_act      (cfg_act),
    .sdo          (sdo),
    .sdo_oe       (sdo_oe),
    .dat_path_sel (dat_path_sel),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .reg_flat     (reg_flat)
);

// File: tb/sim_spi_cfg_port.sv
// Self-checking bench: sweeps every register through serial writes and reads,
// then covers framing errors, aborts, select priority and chained accesses.
module sim_spi_cfg_port;

    localparam int AW = 5;
    localparam int DW = AW + 3;
    localparam int NR = 1 << AW;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          sdi = 1'b0;
    logic          cfg_sel_n = 1'b1;
    logic          dat_sel_n = 1'b1;
    logic          sdo, sdo_oe, dat_path_sel, wr_stb, cmd_bad;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [NR*DW-1:0] reg_flat;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int bad_cnt = 0;
    logic [7:0] model [NR];

    always #5 clk = ~clk;

    spi_cfg_port #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi),
        .cfg_sel_n(cfg_sel_n), .dat_sel_n(dat_sel_n),
        .sdo(sdo), .sdo_oe(sdo_oe), .dat_path_sel(dat_path_sel),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_bad(cmd_bad), .reg_flat(reg_flat)
    );

    // Count strobes and framing-error pulses seen at the ports.
    always @(posedge clk) begin
        if (rst_n && wr_stb) stb_cnt <= stb_cnt + 1;
        if (rst_n && cmd_bad) bad_cnt <= bad_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] word(input int a);
        return reg_flat[a*DW +: DW];
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 7) ^ 8'hA5);
    endfunction

    // Clock nb bits of v out MSB first; capture sdo just before each rise.
    task automatic send_bits(input logic [7:0] v, input int nb, output logic [7:0] got);
        got = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = v[i];
            tick(H);
            got[i] = sdo;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    task automatic access(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rdv);
        logic [7:0] junk;
        cfg_sel_n = 1'b0;
        tick(H);
        send_bits(cmd, 8, junk);
        send_bits(dat, 8, rdv);
        tick(H);
        cfg_sel_n = 1'b1;
        tick(2 * H);
    endtask

    function automatic logic [7:0] wcmd(input int a);
        return {2'b00, 5'(a), 1'b0};
    endfunction

    function automatic logic [7:0] rcmd(input int a);
        return {2'b01, 5'(a), 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r, junk;
        int s0, b0;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        check(reg_flat == '0, "R1 regs", 0, 0);
        check(sdo == 1'b0 && sdo_oe == 1'b0, "R1 sdo", {sdo, sdo_oe}, 0);
        check(stb_cnt == 0, "R1 strobe", stb_cnt, 0);
        for (int a = 0; a < NR; a++) model[a] = 8'h00;

        // R2 write every register; R9 one strobe per write
        for (int a = 0; a < NR; a++) begin
            access(wcmd(a), pat(a), r);
            model[a] = pat(a);
        end
        for (int a = 0; a < NR; a++)
            check(word(a) == model[a], "R2 write", word(a), model[a]);
        check(stb_cnt == NR, "R9 strobe count", stb_cnt, NR);

        // R3 read every register back; R7 quiet when deselected
        for (int a = 0; a < NR; a++) begin
            access(rcmd(a), 8'hFF, r);
            check(r == model[a], "R3 read", r, model[a]);
        end
        check(stb_cnt == NR, "R3 no write on read", stb_cnt, NR);
        check(word(5) == model[5], "R3 regs held", word(5), model[5]);
        check(sdo == 1'b0 && sdo_oe == 1'b0, "R7 deselected", {sdo, sdo_oe}, 0);

        // R4 bad start bit, bad stop bit, badly framed read
        s0 = stb_cnt; b0 = bad_cnt;
        access(wcmd(4) | 8'h80, 8'h3C, r);
        check(word(4) == model[4], "R4 start bit", word(4), model[4]);
        access(wcmd(9) | 8'h01, 8'hC3, r);
        check(word(9) == model[9], "R4 stop bit", word(9), model[9]);
        access(rcmd(12) | 8'h01, 8'h00, r);
        check(r == 8'h00, "R4 bad read data", r, 0);
        check(stb_cnt == s0, "R4 no strobe", stb_cnt, s0);
        check(bad_cnt == b0 + 3, "R4 flag count", bad_cnt, b0 + 3);

        // R5 abort inside the command byte, then a clean write
        cfg_sel_n = 1'b0; tick(H);
        send_bits(wcmd(2), 5, junk);
        tick(H); cfg_sel_n = 1'b1; tick(2 * H);
        check(stb_cnt == s0, "R5 abort cmd", stb_cnt, s0);
        access(wcmd(2), 8'h5A, r);
        model[2] = 8'h5A;
        check(word(2) == 8'h5A, "R5 fresh start", word(2), 8'h5A);
        // R5 abort inside the data byte
        cfg_sel_n = 1'b0; tick(H);
        send_bits(wcmd(6), 8, junk);
        send_bits(8'h0F, 4, junk);
        tick(H); cfg_sel_n = 1'b1; tick(2 * H);
        check(word(6) == model[6], "R5 abort data", word(6), model[6]);
        check(stb_cnt == s0 + 1, "R5 abort strobe", stb_cnt, s0 + 1);

        // R6 data select alone: no config traffic
        dat_sel_n = 1'b0; tick(4);
        check(dat_path_sel == 1'b1, "R6 data path", dat_path_sel, 1);
        check(sdo_oe == 1'b0, "R6 oe off", sdo_oe, 0);
        send_bits(wcmd(7), 8, junk);
        send_bits(8'h99, 8, junk);
        tick(2 * H);
        check(word(7) == model[7], "R6 no write", word(7), model[7]);
        // R6 both selects low: configuration wins
        cfg_sel_n = 1'b0; tick(H);
        check(dat_path_sel == 1'b0 && sdo_oe == 1'b1, "R6 priority", {dat_path_sel, sdo_oe}, 1);
        send_bits(wcmd(7), 8, junk);
        send_bits(8'h99, 8, junk);
        tick(H); cfg_sel_n = 1'b1; tick(2 * H);
        model[7] = 8'h99;
        check(word(7) == 8'h99, "R6 config write", word(7), 8'h99);
        dat_sel_n = 1'b1; tick(4);

        // R8 chained accesses in one select-low period
        cfg_sel_n = 1'b0; tick(H);
        send_bits(wcmd(10), 8, junk);
        send_bits(8'hE1, 8, junk);
        send_bits(rcmd(10), 8, junk);
        send_bits(8'h00, 8, r);
        check(r == 8'hE1, "R8 read after write", r, 8'hE1);
        send_bits(wcmd(11), 8, junk);
        send_bits(8'h1E, 8, junk);
        tick(H); cfg_sel_n = 1'b1; tick(2 * H);
        check(word(10) == 8'hE1, "R8 first", word(10), 8'hE1);
        check(word(11) == 8'h1E, "R8 second", word(11), 8'h1E);
        check(word(0) == model[0], "R8 others", word(0), model[0]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule